// File: doc/BRIEF.md
# Hard Decision Output Buffer

This block sits at the output of an iterative soft-decision decoder. When the decoder finishes the programmed iterations for a block, it writes the final log-likelihood ratio (LLR) of each symbol into the buffer, addressed by symbol index. The buffer does not keep the LLR. It keeps only the decided bit taken from that LLR, which is 1 when the LLR is strictly positive and 0 otherwise. The decoder then pulses an end-of-block strobe together with the block length. After that, a ready flag tells the downstream consumer that decided bits are waiting.

The consumer reads the bits one at a time, in address order, by raising a read strobe. Deasserting the strobe pauses the stream. The bit memory is separate from the decoder's LLR memory, so the decoder can start its next block as soon as it has handed the LLRs over. The buffer holds one block. While that block is still being drained, a full flag is raised and any further writes are refused. After the last bit has been taken, the full flag drops, and the next block's bits can be written in the very next cycle.

Top module: `hd_out_buffer`

## Requirements
- R1: The stored bit for an LLR word, read as two's complement, is 1 only when the value is greater than zero. A zero value and every negative value, including the most negative one, store 0.
- R2: While reset is held, and after it is released, `out_ready` and `wr_full` are 0. `out_bit` is 0 whenever `out_ready` is 0.
- R3: `out_ready` goes high on the clock edge that samples `blk_done` high while the buffer is not full. It is never high before that edge.
- R4: While `out_ready` is high, `out_bit` shows the stored bit at the current read position. The read position starts at address 0, and each cycle with `rd_strobe` high moves it forward by one. This delivers the bits in address order, whatever order they were written in.
- R5: A cycle with `rd_strobe` low leaves the read position unchanged, so the same bit is presented again.
- R6: The strobe that takes the bit at address `blk_len`-1 makes `out_ready` fall on that clock edge. The next block is then read again from address 0.
- R7: `wr_full` equals `out_ready`. While it is high, `wr_en` and `blk_done` have no effect: the stored bits and the stored block length remain those of the block being drained.
- R8: When `wr_full` is low, a write and `blk_done` may share one cycle. The write lands, and the block becomes readable at once, with no idle cycles after the previous block's drain.
- R9: `rd_strobe` has no effect while `out_ready` is low.
- R10: Block lengths from 1 up to DEPTH (64 by default) are supported, with `blk_len` taken as an unsigned count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one final LLR word |
| wr_addr | input | AW (6) | Symbol index of the LLR word |
| wr_llr | input | LLR_W (8) | Final LLR, two's complement |
| blk_done | input | 1 | Decoder has completed its iterations for this block |
| blk_len | input | AW+1 (7) | Number of symbols in the block, sampled with blk_done |
| wr_full | output | 1 | Backpressure: the store holds an undrained block |
| rd_strobe | input | 1 | Consumer takes the presented bit |
| out_ready | output | 1 | Decided bits are available |
| out_bit | output | 1 | Decided bit at the current read position |

## Verification
The assertions rely on two things about the writer. First, `blk_len` lies between 1 and DEPTH whenever `blk_done` is accepted. Second, every address below that length is written before the block is closed. The length assumption is checked by an assertion of its own. The bench writes every address of each block, in forward or reverse order, before or together with `blk_done`, and uses only lengths within the legal range, including both end values. Writes and `blk_done` pulses outside these rules are sent only while `wr_full` is high, where the block must discard them.

// File: rtl/hdo_pkg.sv
package hdo_pkg;
    // Occupancy of the single-block bit store
    typedef enum logic {
        PH_FILL  = 1'b0,   // accepting writes from the decoder
        PH_DRAIN = 1'b1    // bits held for the consumer
    } phase_e;

    // Sign-based hard decision: strictly positive gives 1
    function automatic logic llr_to_bit(input logic signed [31:0] v);
        return (v > 0);
    endfunction
endpackage

// File: rtl/hdo_slicer.sv
module hdo_slicer #(
    parameter int LLR_W = 8
) (
    input  logic [LLR_W-1:0] llr,
    output logic             bit_o
);
    import hdo_pkg::*;

    logic signed [31:0] llr_ext;

    always_comb begin
        llr_ext = 32'(signed'(llr));
        bit_o   = llr_to_bit(llr_ext);
    end
endmodule

// File: rtl/hdo_bit_store.sv
module hdo_bit_store #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_allow,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);
    logic [DEPTH-1:0] bits_d, bits_q;
    logic [DEPTH-1:0] row_we;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_row
            assign row_we[g] = wr_allow && (wr_addr == AW'(g));
            assign bits_d[g] = row_we[g] ? wr_bit : bits_q[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign rd_bit = bits_q[rd_addr];

    // R7: contents are frozen whenever writes are refused
    p_store_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allow |=> $stable(bits_q));
endmodule

// File: rtl/hdo_drain_ctrl.sv
module hdo_drain_ctrl #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_done,
    input  logic [CW-1:0] blk_len,
    input  logic          rd_strobe,
    output logic          ready,
    output logic [AW-1:0] rd_ptr
);
    import hdo_pkg::*;

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] ptr;
        logic [CW-1:0] len;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  at_last;

    always_comb begin
        st_d    = st_q;
        at_last = ({1'b0, st_q.ptr} == (st_q.len - CW'(1)));
        if (st_q.phase == PH_DRAIN) begin
            if (rd_strobe) begin
                if (at_last) begin
                    st_d.phase = PH_FILL;
                    st_d.ptr   = '0;
                end else begin
                    st_d.ptr = st_q.ptr + AW'(1);
                end
            end
        end else if (blk_done) begin
            st_d.phase = PH_DRAIN;
            st_d.len   = blk_len;
            st_d.ptr   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_FILL;
            st_q.ptr   <= '0;
            st_q.len   <= CW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign ready  = (st_q.phase == PH_DRAIN);
    assign rd_ptr = st_q.ptr;

    // R10: an accepted block length must be legal (input assumption)
    p_len_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && !ready) |-> (blk_len != '0 && blk_len <= CW'(DEPTH)));
    // R3: ready only rises after an end-of-block strobe
    p_ready_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(blk_done));
    // R5: idle strobe holds the read position
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !rd_strobe) |=> $stable(rd_ptr) && ready);
    // R6: taking the last bit ends the drain
    p_drain_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rd_strobe && ({1'b0, rd_ptr} == st_q.len - CW'(1))) |=> !ready && rd_ptr == '0);
    // R4: position stays inside the block
    p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ({1'b0, rd_ptr} < st_q.len));
    // R9: strobes while empty do not move the position
    p_idle_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !blk_done) |=> !ready && $stable(rd_ptr));
endmodule

// File: rtl/hd_out_buffer.sv
module hd_out_buffer #(
    parameter int LLR_W = 8,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LLR_W-1:0] wr_llr,
    input  logic             blk_done,
    input  logic [CW-1:0]    blk_len,
    output logic             wr_full,
    input  logic             rd_strobe,
    output logic             out_ready,
    output logic             out_bit
);
    logic          dec_bit;
    logic          wr_allow;
    logic          ready;
    logic [AW-1:0] rd_ptr;
    logic          rd_bit;

    hdo_slicer #(.LLR_W(LLR_W)) slicer_i (
        .llr   (wr_llr),
        .bit_o (dec_bit)
    );

    assign wr_allow = wr_en && !ready;

    hdo_bit_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_allow (wr_allow),
        .wr_addr  (wr_addr),
        .wr_bit   (dec_bit),
        .rd_addr  (rd_ptr),
        .rd_bit   (rd_bit)
    );

    hdo_drain_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_done  (blk_done),
        .blk_len   (blk_len),
        .rd_strobe (rd_strobe),
        .ready     (ready),
        .rd_ptr    (rd_ptr)
    );

    assign wr_full   = ready;
    assign out_ready = ready;
    assign out_bit   = ready & rd_bit;

    // R2: no bit is shown while nothing is ready
    p_quiet_output_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !out_bit);
    // R8: a write in a not-full cycle updates the presented data path
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_full && blk_done && wr_addr == '0 && blk_len != '0)
        |=> out_ready && (out_bit == $past(dec_bit)));
endmodule

// File: tb/hd_out_buffer_tb_top.sv
`timescale 1ns/1ps
module hd_out_buffer_tb_top;
    localparam int LLR_W = 8;
    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int CW    = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [LLR_W-1:0] wr_llr = '0;
    logic             blk_done = 1'b0;
    logic [CW-1:0]    blk_len = '0;
    logic             wr_full;
    logic             rd_strobe = 1'b0;
    logic             out_ready;
    logic             out_bit;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    hd_out_buffer #(.LLR_W(LLR_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_llr(wr_llr), .blk_done(blk_done), .blk_len(blk_len),
        .wr_full(wr_full), .rd_strobe(rd_strobe), .out_ready(out_ready),
        .out_bit(out_bit)
    );

    typedef struct packed {
        logic [6:0] len;
        logic [7:0] seed;
        logic       rev;
        logic       gaps;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{7'd1,  8'd4,  1'b0, 1'b0},
        '{7'd9,  8'd17, 1'b0, 1'b1},
        '{7'd23, 8'd90, 1'b1, 1'b0},
        '{7'd64, 8'd33, 1'b0, 1'b1},
        '{7'd64, 8'd201,1'b1, 1'b0},
        '{7'd2,  8'd7,  1'b1, 1'b1}
    };

    function automatic logic [7:0] llr_of(int seed, int i);
        if (i % 7 == 3)  return 8'h00;
        if (i % 11 == 5) return 8'h80;
        return 8'((i * 37 + seed * 11 + 5) % 256);
    endfunction

    function automatic logic exp_bit(logic [7:0] v);
        return (v != 8'h00) && !v[7];
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Writes a whole block; closes it together with the final write (R8)
    task automatic write_block(input int len, input int seed, input logic rev);
        for (int k = 0; k < len; k++) begin
            int idx = rev ? (len - 1 - k) : k;
            chk(out_ready == 1'b0, "R3 early ready", int'(out_ready), 0);
            wr_en   = 1'b1;
            wr_addr = AW'(idx);
            wr_llr  = llr_of(seed, idx);
            if (k == len - 1) begin
                blk_done = 1'b1;
                blk_len  = CW'(len);
            end
            tick();
        end
        wr_en    = 1'b0;
        blk_done = 1'b0;
        chk(out_ready == 1'b1, "R3 ready after done", int'(out_ready), 1);
        chk(wr_full == 1'b1, "R7 full while ready", int'(wr_full), 1);
    endtask

    task automatic drain(input int len, input int seed, input logic gaps);
        for (int i = 0; i < len; i++) begin
            logic e = exp_bit(llr_of(seed, i));
            chk(out_ready == 1'b1, "R4 ready during drain", int'(out_ready), 1);
            chk(out_bit == e, "R1 R4 bit value", int'(out_bit), int'(e));
            if (gaps && (i % 3 == 1)) begin
                rd_strobe = 1'b0;
                tick();
                chk(out_bit == e && out_ready, "R5 held bit", int'(out_bit), int'(e));
            end
            rd_strobe = 1'b1;
            tick();
            rd_strobe = 1'b0;
        end
        chk(out_ready == 1'b0, "R6 ready falls after last", int'(out_ready), 0);
        chk(wr_full == 1'b0, "R7 full clears", int'(wr_full), 0);
        chk(out_bit == 1'b0, "R2 quiet output", int'(out_bit), 0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        chk(out_ready == 1'b0, "R2 ready in reset", int'(out_ready), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk(out_ready == 1'b0, "R2 ready after reset", int'(out_ready), 0);
        chk(wr_full == 1'b0, "R2 full after reset", int'(wr_full), 0);
        chk(out_bit == 1'b0, "R2 bit after reset", int'(out_bit), 0);

        // R9: strobes while empty must not move the read position
        rd_strobe = 1'b1;
        repeat (3) tick();
        rd_strobe = 1'b0;
        chk(out_ready == 1'b0, "R9 strobe while empty", int'(out_ready), 0);
        write_block(5, 9, 1'b0);
        drain(5, 9, 1'b0);

        // Main table: R1 R4 R5 R6 R8 R10, back to back
        for (int v = 0; v < 6; v++) begin
            write_block(int'(VECS[v].len), int'(VECS[v].seed), VECS[v].rev);
            drain(int'(VECS[v].len), int'(VECS[v].seed), VECS[v].gaps);
        end

        // R7: writes and a second done while full are ignored
        write_block(8, 3, 1'b0);
        for (int a = 0; a < DEPTH; a++) begin
            wr_en   = 1'b1;
            wr_addr = AW'(a);
            wr_llr  = exp_bit(llr_of(3, a)) ? 8'h80 : 8'h01;
            blk_done = (a == 10);
            blk_len  = CW'(20);
            tick();
        end
        wr_en = 1'b0;
        blk_done = 1'b0;
        chk(out_ready == 1'b1, "R7 still ready", int'(out_ready), 1);
        drain(8, 3, 1'b1);

        // R8: write and done in one cycle right after a drain
        wr_en = 1'b1; wr_addr = '0; wr_llr = 8'h7F; blk_done = 1'b1; blk_len = CW'(1);
        tick();
        wr_en = 1'b0; blk_done = 1'b0;
        chk(out_ready == 1'b1 && out_bit == 1'b1, "R8 single-cycle block", int'(out_bit), 1);
        drain(1, 0, 1'b0);
        // R1: zero and most negative decide 0, +1 decides 1
        wr_en = 1'b1; wr_addr = AW'(0); wr_llr = 8'h00; tick();
        wr_addr = AW'(1); wr_llr = 8'h80; tick();
        wr_addr = AW'(2); wr_llr = 8'h01; blk_done = 1'b1; blk_len = CW'(3); tick();
        wr_en = 1'b0; blk_done = 1'b0;
        chk(out_bit == 1'b0, "R1 zero llr", int'(out_bit), 0);
        rd_strobe = 1'b1; tick();
        chk(out_bit == 1'b0, "R1 min llr", int'(out_bit), 0);
        tick();
        chk(out_bit == 1'b1, "R1 plus one", int'(out_bit), 1);
        rd_strobe = 1'b0;

        // R2: reset in the middle of a drain clears the ready flag
        rst_n = 1'b0;
        #1;
        chk(out_ready == 1'b0, "R2 reset mid drain", int'(out_ready), 0);
        tick();
        rst_n = 1'b1;
        tick();
        chk(wr_full == 1'b0, "R2 full after mid reset", int'(wr_full), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule